// File: doc/BRIEF.md
# Segment Descriptor Loader with Hidden Cache

This block writes the visible selector of one of eight selector-holding registers (six data and code segment registers, the local-table register and the task register) and refills the matching hidden cache entry. That entry holds the base, the effective limit, the access-rights bits and a usable flag. In protected operation the selector indexes the global descriptor table. The table's base and limit come from a 48-bit global-table register. The block fetches the 8-byte descriptor as two 32-bit reads over a simple request/response memory port. It then checks the selector and the descriptor against per-register rules and either commits the cache entry or reports a fault vector. In real-address operation no memory is touched: the cache is built directly from the 16-bit value.

The block also holds the 48-bit global-table and interrupt-table registers. It loads them from, and returns them to, a 48-bit data path. Each request is offered with `req_valid` while the block is idle. A single-cycle `done` pulse ends every request. `fault` and `fault_vec` qualify that pulse. Cache contents are read through a registered port with one cycle of latency.

Top module: `seg_desc_loader`

## Requirements
- R1: Op code 1 loads `req_tbl` into the global-table register and op code 2 loads it into the interrupt-table register. Op codes 3 and 4 return the global-table and interrupt-table register respectively on `store_data`. Each of these completes with `done` in the cycle after acceptance, and with `fault` low. Both registers hold the base in bits 47:16 and the limit in bits 15:0.
- R2: With `pe_mode` low, a load (op 0) into register codes 0..5 (0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS) completes in the cycle after acceptance without any memory read. It sets the selector to the value, the base to value×16, the limit to 0xFFFF, the rights to 12'h093 and usable to 1.
- R3: With `pe_mode` low, a load into code 6 (local-table register) or code 7 (task register) faults with vector 6 and leaves that cache entry unchanged.
- R4: In protected operation, a load of a non-null selector that passes the R5 and R6 checks raises `busy`. It issues a one-cycle `mem_rd` at global-table base + index×8 (index = selector bits 15:3). After the response arrives it issues a second one-cycle `mem_rd` at that address + 4. The first word holds descriptor bits 31:0 and the second word holds bits 63:32.
- R5: A selector whose index×8+7 exceeds the global-table limit faults with vector 13, and no memory read takes place.
- R6: A non-null selector with bit 2 set (local-table indicator) faults with vector 13, and no memory read takes place.
- R7: A selector with bits 15:2 all zero is null. For codes 0, 3, 4 and 5 it stores the selector, clears usable, and does no read. For codes 1, 2, 6 and 7 it faults with vector 13.
- R8: Descriptor type field = bits 43:40 and S = bit 44. Code 1 requires S=1 and type bit 3 = 1. Code 2 requires S=1, type bit 3 = 0 and type bit 1 = 1. Codes 0, 3, 4 and 5 require S=1 and either type bit 3 = 0 or type bit 1 = 1. Code 6 requires S=0 and type 2. Code 7 requires S=0 and type 1 or 9. A descriptor that breaks its rule faults with vector 13.
- R9: A descriptor that passes R8 but has P (bit 47) = 0 faults with vector 12 for code 2 and with vector 11 for every other code.
- R10: A load that passes all checks stores the selector, base {bits 63:56, 39:32, 31:16} and rights {bits 55:52, 47:40}, and sets usable to 1. It also stores the limit: {bits 51:48, 15:0} zero-extended when G (bit 55) = 0, or that value followed by 12'hFFF when G = 1.
- R11: Every fault leaves the addressed cache entry unchanged. `fault` is high only together with `done`, and `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pe_mode | input | 1 | 1 = protected operation, 0 = real-address operation |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_op | input | 3 | 0 load selector, 1/2 load global/interrupt table reg, 3/4 store them |
| req_reg | input | 3 | Target register code |
| req_sel | input | 16 | Selector value |
| req_tbl | input | 48 | Table-register load value |
| busy | output | 1 | Descriptor fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion ended in a fault |
| fault_vec | output | 8 | Fault vector (6, 11, 12, 13) |
| store_data | output | 48 | Table register returned by a store op |
| mem_rd | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| rd_reg | input | 3 | Cache read register code |
| rd_sel | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached effective limit |
| rd_attr | output | 12 | Cached rights {flags, access byte} |
| rd_usable | output | 1 | Cached usable flag |

## Verification
On every cycle the assertions check the handshake shape. A read request only occurs while busy and lasts one cycle. A fetch always starts with a read. A fault only accompanies done, done never overlaps busy, and the vector is one of the four legal codes. The scenarios cover what depends on data and history: read addresses, the per-register type rules, the order of the type and presence checks, G scaling, the real-address cache contents, and the fact that a rejected load leaves an earlier cache entry intact.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam logic [2:0] OP_LOAD_SEG  = 3'd0;
  localparam logic [2:0] OP_LOAD_GDT  = 3'd1;
  localparam logic [2:0] OP_LOAD_IDT  = 3'd2;
  localparam logic [2:0] OP_STORE_GDT = 3'd3;
  localparam logic [2:0] OP_STORE_IDT = 3'd4;

  localparam logic [2:0] REG_ES  = 3'd0;
  localparam logic [2:0] REG_CS  = 3'd1;
  localparam logic [2:0] REG_SS  = 3'd2;
  localparam logic [2:0] REG_LDT = 3'd6;
  localparam logic [2:0] REG_TSK = 3'd7;

  localparam logic [7:0] VEC_UD  = 8'd6;
  localparam logic [7:0] VEC_NP  = 8'd11;
  localparam logic [7:0] VEC_STK = 8'd12;
  localparam logic [7:0] VEC_GP  = 8'd13;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] limit;
    logic [11:0] attr;
    logic        usable;
  } cache_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WLO, ST_WHI, ST_CHK} fsm_e;
endpackage

// File: rtl/seg_rules.sv
module seg_rules
  import segld_pkg::*;
(
  input  logic [2:0]  reg_id,
  input  logic [63:0] desc,
  output logic        ok,
  output logic [7:0]  vec
);
  logic [3:0] typ;
  logic       s_bit, p_bit, type_ok;

  assign typ   = desc[43:40];
  assign s_bit = desc[44];
  assign p_bit = desc[47];

  always_comb begin
    case (reg_id)
      REG_CS:  type_ok = s_bit & typ[3];
      REG_SS:  type_ok = s_bit & ~typ[3] & typ[1];
      REG_LDT: type_ok = ~s_bit & (typ == 4'd2);
      REG_TSK: type_ok = ~s_bit & ((typ == 4'd1) | (typ == 4'd9));
      default: type_ok = s_bit & (~typ[3] | typ[1]);
    endcase
    ok  = type_ok & p_bit;
    if (!type_ok)            vec = VEC_GP;
    else if (!p_bit)         vec = (reg_id == REG_SS) ? VEC_STK : VEC_NP;
    else                     vec = 8'd0;
  end
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file #(
  parameter int DEPTH = 8,
  parameter int W     = 93,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import segld_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int TBL_W  = 48,
  localparam int RW    = $clog2(NREG),
  localparam int CW    = $bits(cache_t)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pe_mode,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [RW-1:0]    req_reg,
  input  logic [15:0]      req_sel,
  input  logic [TBL_W-1:0] req_tbl,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [7:0]       fault_vec,
  output logic [TBL_W-1:0] store_data,
  output logic             mem_rd,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic [RW-1:0]    rd_reg,
  output logic [15:0]      rd_sel,
  output logic [31:0]      rd_base,
  output logic [31:0]      rd_limit,
  output logic [11:0]      rd_attr,
  output logic             rd_usable
);
  fsm_e             state;
  logic [TBL_W-1:0] gdtr_q, idtr_q;
  logic [RW-1:0]    reg_q;
  logic [15:0]      sel_q;
  logic [31:0]      dlo_q, dhi_q;
  logic [63:0]      desc;

  logic             rule_ok;
  logic [7:0]       rule_vec;

  logic             cw_en;
  logic [RW-1:0]    cw_addr;
  cache_t           cw_data, real_ent, desc_ent, rd_ent;
  logic [CW-1:0]    rd_raw;

  logic             imm_done, imm_fault, start_fetch;
  logic [7:0]       imm_vec;
  logic [12:0]      idx;
  logic             is_null, is_data, is_sys;
  logic [15:0]      span;

  assign desc    = {dhi_q, dlo_q};
  assign idx     = req_sel[15:3];
  assign is_null = (req_sel[15:2] == 14'd0);
  assign is_sys  = (req_reg >= REG_LDT);
  assign is_data = !is_sys && (req_reg != REG_CS) && (req_reg != REG_SS);
  assign span    = {idx, 3'b111};

  seg_rules u_rules (
    .reg_id (reg_q),
    .desc   (desc),
    .ok     (rule_ok),
    .vec    (rule_vec)
  );

  always_comb begin
    real_ent.sel    = req_sel;
    real_ent.base   = {12'd0, req_sel, 4'd0};
    real_ent.limit  = 32'h0000_FFFF;
    real_ent.attr   = 12'h093;
    real_ent.usable = 1'b1;

    desc_ent.sel    = sel_q;
    desc_ent.base   = {desc[63:56], desc[39:32], desc[31:16]};
    desc_ent.limit  = desc[55] ? {desc[51:48], desc[15:0], 12'hFFF}
                               : {12'd0, desc[51:48], desc[15:0]};
    desc_ent.attr   = {desc[55:52], desc[47:40]};
    desc_ent.usable = 1'b1;
  end

  always_comb begin
    cw_en       = 1'b0;
    cw_addr     = req_reg;
    cw_data     = real_ent;
    imm_done    = 1'b0;
    imm_fault   = 1'b0;
    imm_vec     = 8'd0;
    start_fetch = 1'b0;
    if (state == ST_IDLE && req_valid && req_op == OP_LOAD_SEG) begin
      if (!pe_mode) begin
        imm_done = 1'b1;
        if (is_sys) begin
          imm_fault = 1'b1;
          imm_vec   = VEC_UD;
        end else begin
          cw_en = 1'b1;
        end
      end else if (is_null) begin
        imm_done = 1'b1;
        if (is_data) begin
          cw_en          = 1'b1;
          cw_data        = '0;
          cw_data.sel    = req_sel;
        end else begin
          imm_fault = 1'b1;
          imm_vec   = VEC_GP;
        end
      end else if (req_sel[2] || span > gdtr_q[15:0]) begin
        imm_done  = 1'b1;
        imm_fault = 1'b1;
        imm_vec   = VEC_GP;
      end else begin
        start_fetch = 1'b1;
      end
    end else if (state == ST_CHK) begin
      cw_en   = rule_ok;
      cw_addr = reg_q;
      cw_data = desc_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      fault      <= 1'b0;
      fault_vec  <= 8'd0;
      mem_rd     <= 1'b0;
      mem_addr   <= 32'd0;
      gdtr_q     <= '0;
      idtr_q     <= '0;
      store_data <= '0;
      reg_q      <= '0;
      sel_q      <= 16'd0;
      dlo_q      <= 32'd0;
      dhi_q      <= 32'd0;
    end else begin
      done   <= 1'b0;
      fault  <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          reg_q <= req_reg;
          sel_q <= req_sel;
          case (req_op)
            OP_LOAD_GDT:  begin gdtr_q <= req_tbl; done <= 1'b1; end
            OP_LOAD_IDT:  begin idtr_q <= req_tbl; done <= 1'b1; end
            OP_STORE_GDT: begin store_data <= gdtr_q; done <= 1'b1; end
            OP_STORE_IDT: begin store_data <= idtr_q; done <= 1'b1; end
            OP_LOAD_SEG: begin
              done      <= imm_done;
              fault     <= imm_fault;
              fault_vec <= imm_vec;
              if (start_fetch) begin
                busy     <= 1'b1;
                mem_rd   <= 1'b1;
                mem_addr <= gdtr_q[47:16] + {16'd0, idx, 3'b000};
                state    <= ST_WLO;
              end
            end
            default: done <= 1'b1;
          endcase
        end
        ST_WLO: if (mem_rvalid) begin
          dlo_q    <= mem_rdata;
          mem_rd   <= 1'b1;
          mem_addr <= mem_addr + 32'd4;
          state    <= ST_WHI;
        end
        ST_WHI: if (mem_rvalid) begin
          dhi_q <= mem_rdata;
          state <= ST_CHK;
        end
        default: begin
          busy      <= 1'b0;
          done      <= 1'b1;
          fault     <= ~rule_ok;
          fault_vec <= rule_vec;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  seg_cache_file #(.DEPTH(NREG), .W(CW)) u_cache (
    .clk   (clk),
    .we    (cw_en),
    .waddr (cw_addr),
    .wdata (cw_data),
    .raddr (rd_reg),
    .rdata (rd_raw)
  );

  assign rd_ent    = cache_t'(rd_raw);
  assign rd_sel    = rd_ent.sel;
  assign rd_base   = rd_ent.base;
  assign rd_limit  = rd_ent.limit;
  assign rd_attr   = rd_ent.attr;
  assign rd_usable = rd_ent.usable;
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       fault,
  input logic [7:0] fault_vec,
  input logic       mem_rd
);
  // R11
  fault_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);
  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3 R5 R8 R9
  legal_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (fault_vec == 8'd6 || fault_vec == 8'd11 ||
                         fault_vec == 8'd12 || fault_vec == 8'd13));
  // R4
  read_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);
  // R4
  read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R4
  fetch_starts_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_rd);
endmodule

bind seg_desc_loader seg_desc_loader_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .fault_vec (fault_vec),
  .mem_rd    (mem_rd)
);

// File: tb/seg_desc_loader_test.sv
module seg_desc_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pe_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [2:0]  req_reg = 3'd0;
  logic [15:0] req_sel = 16'd0;
  logic [47:0] req_tbl = 48'd0;
  logic        busy, done, fault, mem_rd;
  logic [7:0]  fault_vec;
  logic [47:0] store_data;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic [2:0]  rd_reg = 3'd0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base, rd_limit;
  logic [11:0] rd_attr;
  logic        rd_usable;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  seg_desc_loader uut (
    .clk(clk), .rst(rst), .pe_mode(pe_mode), .req_valid(req_valid),
    .req_op(req_op), .req_reg(req_reg), .req_sel(req_sel), .req_tbl(req_tbl),
    .busy(busy), .done(done), .fault(fault), .fault_vec(fault_vec),
    .store_data(store_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rd_reg(rd_reg),
    .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit),
    .rd_attr(rd_attr), .rd_usable(rd_usable)
  );

  // memory model: 64 words, two-cycle response
  logic [31:0] mem_w [64];
  logic        p1 = 1'b0;
  logic [31:0] a1 = 32'd0;
  int          rd_cnt = 0;
  logic [31:0] addr_a, addr_b;

  always @(posedge clk) begin
    mem_rvalid <= p1;
    mem_rdata  <= mem_w[a1[7:2]];
    p1 <= mem_rd;
    a1 <= mem_addr;
    if (mem_rd) begin
      rd_cnt = rd_cnt + 1;
      addr_a = addr_b;
      addr_b = mem_addr;
    end
  end

  task automatic put(input int idx, input logic [31:0] base, input logic [19:0] lim,
                     input logic [3:0] flags, input logic [7:0] acc);
    mem_w[16 + idx*2]     = {base[15:0], lim[15:0]};
    mem_w[16 + idx*2 + 1] = {base[31:24], flags, lim[19:16], acc, base[23:16]};
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic        r_fault;
  logic [7:0]  r_vec;
  logic [47:0] r_store;
  int          r_reads;

  task automatic run_op(input logic [2:0] op, input logic [2:0] rg,
                        input logic [15:0] sel, input logic [47:0] tbl);
    int start;
    start = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_reg = rg; req_sel = sel; req_tbl = tbl;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    r_fault = fault; r_vec = fault_vec; r_store = store_data;
    r_reads = rd_cnt - start;
  endtask

  task automatic read_cache(input logic [2:0] rg);
    rd_reg = rg;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("reset busy", busy, 0);
    check("reset done", done, 0);
    check("reset fault", fault, 0);
  endtask

  task automatic t_tables;
    run_op(3'd1, 0, 0, {32'h0000_0040, 16'h003F});
    run_op(3'd2, 0, 0, {32'hABCD_0000, 16'h07FF});
    run_op(3'd3, 0, 0, 0);
    check("R1 store gdtr", r_store, {32'h0000_0040, 16'h003F});
    run_op(3'd4, 0, 0, 0);
    check("R1 store idtr", r_store, {32'hABCD_0000, 16'h07FF});
    check("R1 no fault", r_fault, 0);
  endtask

  task automatic t_real;
    pe_mode = 1'b0;
    run_op(3'd0, 3'd3, 16'h1234, 0);
    check("R2 fault", r_fault, 0);
    check("R2 reads", r_reads, 0);
    read_cache(3'd3);
    check("R2 base", rd_base, 32'h0001_2340);
    check("R2 limit", rd_limit, 32'h0000_FFFF);
    check("R2 attr", rd_attr, 12'h093);
    check("R2 sel/usable", {rd_sel, rd_usable}, {16'h1234, 1'b1});
  endtask

  task automatic t_code_load;
    pe_mode = 1'b1;
    run_op(3'd0, 3'd1, 16'h0008, 0);
    check("R4 reads", r_reads, 2);
    check("R4 first addr", addr_a, 32'h48);
    check("R4 second addr", addr_b, 32'h4C);
    check("R10 fault", r_fault, 0);
    read_cache(3'd1);
    check("R10 base", rd_base, 32'h0001_0000);
    check("R10 limit", rd_limit, 32'h0000_FFFF);
    check("R10 attr", rd_attr, 12'h49A);
  endtask

  task automatic t_gran;
    run_op(3'd0, 3'd3, 16'h0013, 0);
    check("R10 G fault", r_fault, 0);
    read_cache(3'd3);
    check("R10 G limit", rd_limit, 32'h03FF_F000 | 32'h0000_0FFF);
    check("R10 G base", rd_base, 32'h1234_5600);
    check("R10 G attr/sel", {rd_attr, rd_sel}, {12'hC92, 16'h0013});
  endtask

  task automatic t_types;
    run_op(3'd0, 3'd1, 16'h0010, 0);
    check("R8 CS data", {r_fault, r_vec}, {1'b1, 8'd13});
    read_cache(3'd1);
    check("R11 CS kept", rd_sel, 16'h0008);
    run_op(3'd0, 3'd2, 16'h0008, 0);
    check("R8 SS code", {r_fault, r_vec}, {1'b1, 8'd13});
    run_op(3'd0, 3'd2, 16'h0010, 0);
    check("R8 SS data ok", r_fault, 0);
    run_op(3'd0, 3'd4, 16'h0030, 0);
    check("R8 FS exec-only", {r_fault, r_vec}, {1'b1, 8'd13});
    run_op(3'd0, 3'd6, 16'h0020, 0);
    check("R8 LDT ok", r_fault, 0);
    run_op(3'd0, 3'd7, 16'h0028, 0);
    check("R8 TSS ok", r_fault, 0);
    read_cache(3'd7);
    check("R10 TSS cache", {rd_base, rd_attr}, {32'h0000_3000, 12'h089});
    run_op(3'd0, 3'd7, 16'h0020, 0);
    check("R8 TR wrong type", {r_fault, r_vec}, {1'b1, 8'd13});
  endtask

  task automatic t_present;
    run_op(3'd0, 3'd3, 16'h0018, 0);
    check("R9 DS np", {r_fault, r_vec}, {1'b1, 8'd11});
    read_cache(3'd3);
    check("R11 DS kept", rd_sel, 16'h0013);
    run_op(3'd0, 3'd2, 16'h0018, 0);
    check("R9 SS np", {r_fault, r_vec}, {1'b1, 8'd12});
    run_op(3'd0, 3'd1, 16'h0038, 0);
    check("R9 type before present", {r_fault, r_vec}, {1'b1, 8'd13});
  endtask

  task automatic t_limit_ti;
    run_op(3'd0, 3'd0, 16'h0040, 0);
    check("R5 over limit", {r_fault, r_vec}, {1'b1, 8'd13});
    check("R5 no read", r_reads, 0);
    run_op(3'd0, 3'd0, 16'h000C, 0);
    check("R6 local table", {r_fault, r_vec}, {1'b1, 8'd13});
    check("R6 no read", r_reads, 0);
  endtask

  task automatic t_null;
    run_op(3'd0, 3'd5, 16'h0003, 0);
    check("R7 null data", {r_fault, r_reads[1:0]}, 3'b000);
    read_cache(3'd5);
    check("R7 unusable", {rd_sel, rd_usable}, {16'h0003, 1'b0});
    run_op(3'd0, 3'd1, 16'h0000, 0);
    check("R7 null CS", {r_fault, r_vec}, {1'b1, 8'd13});
    run_op(3'd0, 3'd2, 16'h0002, 0);
    check("R7 null SS", {r_fault, r_vec}, {1'b1, 8'd13});
  endtask

  task automatic t_real_sys;
    pe_mode = 1'b0;
    run_op(3'd0, 3'd6, 16'h0028, 0);
    check("R3 LDT real", {r_fault, r_vec}, {1'b1, 8'd6});
    read_cache(3'd6);
    check("R3 LDT kept", rd_sel, 16'h0020);
    run_op(3'd0, 3'd7, 16'h0020, 0);
    check("R3 TR real", {r_fault, r_vec}, {1'b1, 8'd6});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_w[i] = 32'd0;
    put(1, 32'h0001_0000, 20'h0FFFF, 4'h4, 8'h9A);
    put(2, 32'h1234_5600, 20'h03FFF, 4'hC, 8'h92);
    put(3, 32'h0000_5000, 20'h00FFF, 4'h0, 8'h12);
    put(4, 32'h0000_2000, 20'h0007F, 4'h0, 8'h82);
    put(5, 32'h0000_3000, 20'h00067, 4'h0, 8'h89);
    put(6, 32'h0000_4000, 20'h00FFF, 4'h4, 8'h98);
    put(7, 32'h0000_6000, 20'h00FFF, 4'h4, 8'h12);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tables();
    t_real();
    t_code_load();
    t_gran();
    t_types();
    t_present();
    t_limit_ti();
    t_null();
    t_real_sys();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule